// File: doc/BRIEF.md
# Receive Frame Byte Counter

This block measures the length of each frame taken in by a transparent-mode serial receiver. The receive datapath gives it one strobe per accepted byte and one strobe when the frame closes. The block keeps a running 13-bit count and latches it as the frame length when the frame closes. It then raises a frame-end interrupt flag and holds the length still until the host acknowledges the frame. A second finished frame can wait in a one-deep holding slot while the host is still busy with the first.

The host reads the length through an 8-bit read port, as a low byte and a high byte. The block also tells the host how many bytes are left in the receive FIFO for the final read of the frame. The host sets a power-of-two FIFO threshold. The count left is the frame length modulo that threshold, or the whole threshold when the length is an exact multiple of it.

Top module: `rx_frame_len_counter`

## Requirements
- R1: While `xparent_en` is 1, each cycle with `byte_vld` high adds one byte to the running count. A `frame_end` pulse closes the frame, and a byte strobed in the same cycle counts toward that frame. If no frame is pending, `frame_irq` is 1 from the cycle after the `frame_end` edge, and the latched length is visible from that cycle. The running count restarts at zero for the next frame.
- R2: With `rd_hi` = 0, `rd_data` returns length bits 7..0. With `rd_hi` = 1, it returns length bits 12..8 in bit positions 4..0, and bits 7..5 read as 0.
- R3: While `frame_irq` is 1 and `host_ack` is low, the latched length, `len_ovf` and `frame_irq` do not change. A `host_ack` pulse with no frame held in waiting clears `frame_irq`, the length and `len_ovf` to 0 from the next cycle.
- R4: A frame that closes while another is pending goes into a holding slot. The first `host_ack` then makes the held frame current, and `frame_irq` stays 1. A frame that closes while both the current and holding slots are full is dropped.
- R5: The running count saturates at 8191. A frame of more than 8191 bytes reports length 8191 with `len_ovf` = 1. A frame of exactly 8191 bytes reports 8191 with `len_ovf` = 0.
- R6: `thr_sel` selects the FIFO threshold: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64. While `frame_irq` is 1, `final_avail` equals length mod threshold when that is non-zero, and equals the threshold otherwise. `final_avail` follows `thr_sel` combinationally. While `frame_irq` is 0, `final_avail` is 0.
- R7: A `frame_end` with no byte counted since the previous frame end (a zero-length frame) raises no interrupt and changes no latched value.
- R8: While `xparent_en` is 0, `byte_vld` and `frame_end` are ignored, and a partial count is kept for when counting resumes.
- R9: After reset `frame_irq`, `len_ovf`, `final_avail` and `rd_data` are 0. A `host_ack` while `frame_irq` is 0 has no effect.
- R10: When `host_ack` and a valid `frame_end` fall in the same cycle and no frame is held in waiting, the new frame becomes current in the next cycle, and `frame_irq` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xparent_en | input | 1 | Transparent mode enable; counting is active only while this is high |
| byte_vld | input | 1 | One byte received this cycle |
| frame_end | input | 1 | Current frame closes this cycle |
| thr_sel | input | 2 | FIFO threshold select (8, 16, 32, 64) |
| host_ack | input | 1 | Host acknowledges the current frame |
| rd_hi | input | 1 | Read port select: 0 low count byte, 1 high count byte |
| rd_data | output | 8 | Selected count byte |
| frame_irq | output | 1 | Frame-end interrupt flag; a latched length is valid |
| len_ovf | output | 1 | Latched frame exceeded 8191 bytes |
| final_avail | output | 7 | Bytes left in the receive FIFO for the final read |

## Verification
The bench targets lengths at threshold multiples (64 and 96), where a design that leaves out the zero-remainder rule would report 0 bytes left. It drives frames of 8191, 8192 and 8300 bytes: a counter that wraps would report a tiny length, and a bad flag would mark 8191 as overflowed. It closes frames while one is pending, with and without a same-cycle acknowledge, to catch designs that overwrite the latched length, lose the held frame or drop the interrupt for one cycle. It also sends zero-length frames, strobes while transparent mode is off and acknowledges with no frame pending; a careless design would raise a false interrupt or lose its partial count.

// File: rtl/rfbc_pkg.sv
package rfbc_pkg;

    localparam int LEN_W       = 13;
    localparam int RD_W        = 8;
    localparam int LO_W        = 8;
    localparam int HI_W        = LEN_W - LO_W;
    localparam int THR_SEL_W   = 2;
    localparam int THR_MIN_LOG = 3;
    localparam int THR_MAX_LOG = THR_MIN_LOG + (2 ** THR_SEL_W) - 1;
    localparam int AVAIL_W     = THR_MAX_LOG + 1;

    typedef logic [LEN_W-1:0]     len_t;
    typedef logic [AVAIL_W-1:0]   avail_t;
    typedef logic [THR_SEL_W-1:0] thr_sel_t;

    localparam len_t LEN_MAX = '1;

    typedef struct packed {
        logic valid;
        logic ovf;
        len_t len;
    } frame_rec_t;

    localparam frame_rec_t REC_EMPTY = '{valid: 1'b0, ovf: 1'b0, len: '0};

    function automatic avail_t thr_of(thr_sel_t sel);
        return avail_t'(1) << (THR_MIN_LOG + int'(sel));
    endfunction

    function automatic avail_t final_count(len_t len, thr_sel_t sel);
        avail_t thr;
        len_t   mask;
        len_t   rem;
        thr  = thr_of(sel);
        mask = len_t'(thr) - len_t'(1);
        rem  = len & mask;
        return (rem == '0) ? thr : avail_t'(rem);
    endfunction

endpackage

// File: rtl/rfbc_run_counter.sv
module rfbc_run_counter
    import rfbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       byte_vld,
    input  logic       frame_end,
    output frame_rec_t done
);

    len_t cnt_q;
    logic ovf_q;
    len_t cnt_nxt;
    logic ovf_nxt;
    logic take;
    logic close;
    logic at_max;

    always_comb begin
        take    = en & byte_vld;
        close   = en & frame_end;
        at_max  = (cnt_q == LEN_MAX);
        cnt_nxt = cnt_q;
        ovf_nxt = ovf_q;
        if (take) begin
            if (at_max) begin
                ovf_nxt = 1'b1;
            end else begin
                cnt_nxt = cnt_q + len_t'(1);
            end
        end
        done.valid = close & (cnt_nxt != '0);
        done.ovf   = ovf_nxt;
        done.len   = cnt_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (close) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            ovf_q <= ovf_nxt;
        end
    end

    // R5: a byte arriving at the ceiling keeps the count there and flags overflow
    assert_sat_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LEN_MAX && en && byte_vld && !frame_end) |=> (cnt_q == LEN_MAX && ovf_q));

    // R8: with transparent mode off the partial count is frozen
    assert_idle_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(cnt_q) && $stable(ovf_q)));

endmodule

// File: rtl/rfbc_frame_slots.sv
module rfbc_frame_slots
    import rfbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_rec_t done,
    input  logic       ack,
    output frame_rec_t cur
);

    frame_rec_t cur_q;
    frame_rec_t hold_q;
    frame_rec_t cur_d;
    frame_rec_t hold_d;

    always_comb begin
        cur_d  = cur_q;
        hold_d = hold_q;
        if (ack && cur_q.valid) begin
            cur_d  = hold_q;
            hold_d = REC_EMPTY;
        end
        if (done.valid) begin
            if (!cur_d.valid) begin
                cur_d = done;
            end else if (!hold_d.valid) begin
                hold_d = done;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= REC_EMPTY;
            hold_q <= REC_EMPTY;
        end else begin
            cur_q  <= cur_d;
            hold_q <= hold_d;
        end
    end

    assign cur = cur_q;

    // R1: a closed frame with nothing pending is latched by the next cycle
    assert_latch_R1: assert property (@(posedge clk) disable iff (rst)
        (done.valid && !cur_q.valid) |=> cur_q.valid);

    // R3: latched record is frozen until acknowledged
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cur_q.valid && !ack) |=> $stable(cur_q));

    // R4: the holding slot is only ever occupied behind a current frame
    assert_hold_order_R4: assert property (@(posedge clk) disable iff (rst)
        hold_q.valid |-> cur_q.valid);

    // R9: acknowledge with nothing pending leaves the block idle
    assert_stray_ack_R9: assert property (@(posedge clk) disable iff (rst)
        (!cur_q.valid && !done.valid) |=> !cur_q.valid);

endmodule

// File: rtl/rfbc_read_view.sv
module rfbc_read_view
    import rfbc_pkg::*;
(
    input  frame_rec_t        cur,
    input  logic              rd_hi,
    input  thr_sel_t          thr_sel,
    output logic [RD_W-1:0]   rd_data,
    output logic              irq,
    output logic              ovf,
    output avail_t            avail
);

    logic [RD_W-1:0] lo_byte;
    logic [RD_W-1:0] hi_byte;

    always_comb begin
        lo_byte = cur.len[LO_W-1:0];
        hi_byte = {{(RD_W-HI_W){1'b0}}, cur.len[LEN_W-1:LO_W]};
        rd_data = rd_hi ? hi_byte : lo_byte;
        irq     = cur.valid;
        ovf     = cur.valid & cur.ovf;
        avail   = cur.valid ? final_count(cur.len, thr_sel) : '0;
    end

    // R6: with a frame pending the final read size is between 1 and the threshold
    always_comb begin
        if (cur.valid) begin
            assert_avail_range_R6: assert (avail != '0 && avail <= thr_of(thr_sel));
        end
    end

endmodule

// File: rtl/rx_frame_len_counter.sv
module rx_frame_len_counter
    import rfbc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  xparent_en,
    input  logic                  byte_vld,
    input  logic                  frame_end,
    input  logic [THR_SEL_W-1:0]  thr_sel,
    input  logic                  host_ack,
    input  logic                  rd_hi,
    output logic [RD_W-1:0]       rd_data,
    output logic                  frame_irq,
    output logic                  len_ovf,
    output logic [AVAIL_W-1:0]    final_avail
);

    frame_rec_t done;
    frame_rec_t cur;

    rfbc_run_counter u_run (
        .clk       (clk),
        .rst       (rst),
        .en        (xparent_en),
        .byte_vld  (byte_vld),
        .frame_end (frame_end),
        .done      (done)
    );

    rfbc_frame_slots u_slots (
        .clk  (clk),
        .rst  (rst),
        .done (done),
        .ack  (host_ack),
        .cur  (cur)
    );

    rfbc_read_view u_view (
        .cur     (cur),
        .rd_hi   (rd_hi),
        .thr_sel (thr_sel),
        .rd_data (rd_data),
        .irq     (frame_irq),
        .ovf     (len_ovf),
        .avail   (final_avail)
    );

endmodule

// File: tb/sim_rx_frame_len_counter.sv
module sim_rx_frame_len_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xparent_en = 1'b1;
    logic       byte_vld = 1'b0;
    logic       frame_end = 1'b0;
    logic [1:0] thr_sel = 2'd0;
    logic       host_ack = 1'b0;
    logic       rd_hi = 1'b0;
    logic [7:0] rd_data;
    logic       frame_irq;
    logic       len_ovf;
    logic [6:0] final_avail;

    int checks = 0;
    int failures = 0;

    // reference state
    int run_cnt = 0;
    bit run_ovf = 0;
    bit mv = 0, mo = 0, sv = 0, so = 0;
    int ml = 0, sl = 0;

    always #10 clk = ~clk;

    rx_frame_len_counter u0 (
        .clk(clk), .rst(rst), .xparent_en(xparent_en), .byte_vld(byte_vld),
        .frame_end(frame_end), .thr_sel(thr_sel), .host_ack(host_ack),
        .rd_hi(rd_hi), .rd_data(rd_data), .frame_irq(frame_irq),
        .len_ovf(len_ovf), .final_avail(final_avail)
    );

    function automatic int exp_avail(int len, int sel, bit valid);
        int thr;
        int r;
        if (!valid) return 0;
        thr = 8 << sel;
        r = len % thr;
        return (r == 0) ? thr : r;
    endfunction

    function automatic int exp_rd(int len, bit hi);
        return hi ? ((len >> 8) & 31) : (len & 255);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "frame_irq", int'(frame_irq), int'(mv));
        chk(tag, "len_ovf", int'(len_ovf), int'(mv && mo));
        chk(tag, "final_avail", int'(final_avail), exp_avail(ml, int'(thr_sel), mv));
        chk(tag, "rd_data", int'(rd_data), exp_rd(mv ? ml : 0, rd_hi));
    endtask

    task automatic model_clk();
        int n;
        bit no;
        bit dv;
        n = run_cnt;
        no = run_ovf;
        if (xparent_en && byte_vld) begin
            if (n == 8191) no = 1; else n++;
        end
        dv = xparent_en && frame_end && (n != 0);
        if (host_ack && mv) begin
            mv = sv; ml = sl; mo = so;
            sv = 0; sl = 0; so = 0;
        end
        if (dv) begin
            if (!mv) begin mv = 1; ml = n; mo = no; end
            else if (!sv) begin sv = 1; sl = n; so = no; end
        end
        if (xparent_en && frame_end) begin run_cnt = 0; run_ovf = 0; end
        else begin run_cnt = n; run_ovf = no; end
        if (!mv) begin ml = 0; mo = 0; end
    endtask

    // drive at the falling edge, advance one clock, check at the next falling edge
    task automatic cyc(bit bv, bit fe, bit ack, string tag);
        byte_vld = bv;
        frame_end = fe;
        host_ack = ack;
        @(posedge clk);
        model_clk();
        @(negedge clk);
        byte_vld = 0;
        frame_end = 0;
        host_ack = 0;
        check_all(tag);
    endtask

    task automatic send_frame(int len, string tag);
        for (int i = 0; i < len; i++) cyc(1'b1, i == len - 1, 1'b0, tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic ack_now(string tag);
        cyc(1'b0, 1'b0, 1'b1, tag);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_all("R9");
        rd_hi = 1;
        check_all("R9");
        rd_hi = 0;

        // single byte frame, both read bytes, threshold 8
        thr_sel = 0;
        send_frame(1, "R1");
        idle(1, "R1");
        rd_hi = 1; idle(1, "R2");
        rd_hi = 0; idle(1, "R6");
        ack_now("R3");
        idle(1, "R3");

        // exact multiples and remainders at threshold 64
        thr_sel = 3;
        send_frame(64, "R6");
        idle(1, "R6");
        ack_now("R6");
        send_frame(65, "R6");
        idle(1, "R6");
        ack_now("R6");
        send_frame(96, "R6");
        for (int s = 0; s < 4; s++) begin
            thr_sel = 2'(s);
            idle(1, "R6");
        end
        ack_now("R6");

        // long frame held without acknowledge, both bytes visible
        send_frame(300, "R2");
        rd_hi = 1;
        idle(5, "R3");
        rd_hi = 0;
        idle(2, "R2");
        ack_now("R3");

        // holding slot and dropped third frame
        send_frame(10, "R4");
        send_frame(5, "R4");
        send_frame(7, "R4");
        idle(2, "R4");
        ack_now("R4");
        idle(1, "R4");
        ack_now("R4");
        idle(1, "R4");

        // acknowledge together with a closing frame
        send_frame(3, "R10");
        send_frame(3, "R10");
        cyc(1'b1, 1'b1, 1'b1, "R10");
        idle(1, "R10");
        ack_now("R10");
        idle(1, "R10");

        // zero-length frame
        cyc(1'b0, 1'b1, 1'b0, "R7");
        idle(1, "R7");
        send_frame(2, "R7");
        cyc(1'b0, 1'b1, 1'b0, "R7");
        idle(1, "R7");
        ack_now("R7");

        // transparent mode off: strobes ignored, partial count kept
        cyc(1'b1, 1'b0, 1'b0, "R8");
        cyc(1'b1, 1'b0, 1'b0, "R8");
        xparent_en = 0;
        for (int i = 0; i < 6; i++) cyc(1'b1, i == 5, 1'b0, "R8");
        xparent_en = 1;
        send_frame(3, "R8");
        idle(1, "R8");
        ack_now("R8");

        // stray acknowledge
        ack_now("R9");
        ack_now("R9");

        // saturation
        thr_sel = 3;
        send_frame(8191, "R5");
        idle(1, "R5");
        rd_hi = 1; idle(1, "R5"); rd_hi = 0;
        ack_now("R5");
        send_frame(8192, "R5");
        idle(1, "R5");
        ack_now("R5");
        send_frame(8300, "R5");
        idle(1, "R5");
        ack_now("R5");
        send_frame(4, "R5");
        idle(1, "R5");
        ack_now("R5");

        // constrained random traffic
        for (int f = 0; f < 300; f++) begin
            int len;
            len = int'($urandom_range(150, 0));
            thr_sel = 2'($urandom_range(3, 0));
            for (int i = 0; i <= len; i++) begin
                bit bv;
                bit ak;
                bv = (i < len) ? ($urandom_range(3, 0) != 0) : 1'b0;
                ak = ($urandom_range(40, 0) == 0);
                rd_hi = 1'($urandom_range(1, 0));
                xparent_en = ($urandom_range(30, 0) != 0);
                cyc(bv, i == len, ak, "R1");
            end
            xparent_en = 1;
            if ($urandom_range(2, 0) == 0) ack_now("R3");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule